// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of an 8-bit accumulator machine. It holds the accumulator, a companion byte register that receives a divide remainder, and four status flags: even parity, overflow, auxiliary carry and carry. Each accepted request names one operation and supplies a second operand byte. The carry used by add-with-carry is the block's own carry flag.

Single-byte operations (add, add-with-carry, AND, increment, decrement, clear, complement) finish at the clock edge that accepts them. An unsigned 8-by-8 divide runs in an iterative divider over four cycles and raises a busy output while it runs. Each operation writes only the flags it is defined to affect, through a per-operation update mask. Parity follows every change of the accumulator.

Top module: `acc_flag_alu`

## Requirements
- R1: During and right after reset, accumulator, companion register and all four flags are zero, and busy is low.
- R2: Operation code 0 (add) loads acc+operand mod 256 into the accumulator at the accepting edge. Carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow is the carry into bit 7 XOR the carry out of bit 7.
- R3: Operation code 1 (add with carry) behaves as code 0 with the current carry flag added as a third term. All four flags are updated.
- R4: Operation code 2 loads acc AND operand. Overflow, auxiliary carry and carry are unchanged.
- R5: Operation codes 3 (increment) and 4 (decrement) wrap modulo 256. Overflow, auxiliary carry and carry are unchanged.
- R6: Operation codes 5 (clear to zero) and 6 (bitwise complement) leave overflow, auxiliary carry and carry unchanged.
- R7: The parity flag always equals the XOR of the eight accumulator bits.
- R8: Operation code 7 (divide) divides the accumulator by the operand. Busy is high for the four cycles after the accepting edge. At the fourth edge after acceptance the quotient goes to the accumulator and the remainder to the companion register, carry and overflow are cleared, and auxiliary carry is unchanged.
- R9: A divide by a zero operand sets overflow and clears carry. It leaves 0xFF in the accumulator and the old dividend in the companion register.
- R10: A request made while busy is high is ignored. The companion register changes only when a divide completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when busy_o is low |
| op_i | input | 3 | Operation code, 0 to 7 as listed in the requirements |
| operand_i | input | 8 | Second operand byte, or the divisor |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | Companion register holding the divide remainder |
| flag_p_o | output | 1 | Even-parity flag |
| flag_ov_o | output | 1 | Overflow flag |
| flag_ac_o | output | 1 | Auxiliary carry flag |
| flag_cy_o | output | 1 | Carry flag |
| busy_o | output | 1 | Divide in progress |

## Verification
A multi-cycle divide can coincide with a new request. That includes the last busy cycle, where the divide write-back and a fresh request meet at the same edge. The bench drives a random request on every cycle of every divide. It then checks that the accumulator holds during busy, and that after the write-back the registers and flags match a model in which every request made during busy was discarded. Random operation sequences also chain carries from add into add-with-carry, to test the masked flag updates.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_AND  = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_CLR  = 3'd5,
    OP_CPL  = 3'd6,
    OP_DIV  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic p;
    logic ov;
    logic ac;
    logic cy;
  } flags_t;

  // which flags an operation may write
  function automatic flags_t upd_mask(alu_op_e op);
    flags_t m;
    unique case (op)
      OP_ADD, OP_ADDC: m = '{p: 1'b1, ov: 1'b1, ac: 1'b1, cy: 1'b1};
      OP_DIV:          m = '{p: 1'b1, ov: 1'b1, ac: 1'b0, cy: 1'b1};
      default:         m = '{p: 1'b1, ov: 1'b0, ac: 1'b0, cy: 1'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int unsigned HALF_W = W / 2;

  logic [W:0]      full;
  logic [HALF_W:0] low;
  logic [W-1:0]    upper_in;

  assign full     = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign low      = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin_i};
  assign upper_in = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};

  assign sum_o = full[W-1:0];
  assign cy_o  = full[W];
  assign ac_o  = low[HALF_W];
  assign ov_o  = upper_in[W-1] ^ full[W];
endmodule

// File: rtl/alu_unary.sv
module alu_unary
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_INC:  res_o = a_i + W'(1);
      OP_DEC:  res_o = a_i - W'(1);
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~a_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int unsigned W     = 8,
  parameter int unsigned STEPS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         last_o,
  output logic         zero_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned BITS  = W / STEPS;
  localparam int unsigned CNT_W = $clog2(STEPS + 1);

  logic [W-1:0]     quo_q, rem_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     quo_n, rem_n;
  logic [W:0]       trial, diff;

  // restoring division, BITS quotient bits per cycle
  always_comb begin
    quo_n = quo_q;
    rem_n = rem_q;
    trial = '0;
    diff  = '0;
    for (int i = 0; i < BITS; i++) begin
      trial = {rem_n, quo_n[W-1]};
      diff  = trial - {1'b0, dvs_q};
      quo_n = {quo_n[W-2:0], 1'b0};
      if (trial >= {1'b0, dvs_q}) begin
        rem_n    = diff[W-1:0];
        quo_n[0] = 1'b1;
      end else begin
        rem_n = trial[W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (start_i && !busy_o) begin
      quo_q <= dividend_i;
      rem_q <= '0;
      dvs_q <= divisor_i;
      cnt_q <= CNT_W'(STEPS);
    end else if (busy_o) begin
      quo_q <= quo_n;
      rem_q <= rem_n;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = cnt_q != '0;
  assign last_o = cnt_q == CNT_W'(1);
  assign zero_o = dvs_q == '0;
  assign quo_o  = quo_n;
  assign rem_o  = rem_n;
endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned DIV_STEPS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] operand_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] b_o,
  output logic         flag_p_o,
  output logic         flag_ov_o,
  output logic         flag_ac_o,
  output logic         flag_cy_o,
  output logic         busy_o
);
  alu_op_e      op;
  logic         accept, div_go;
  logic [W-1:0] acc_q, acc_d, b_q, b_d;
  flags_t       flags_q, flags_d, res, mask;

  logic [W-1:0] add_sum, un_res, div_quo, div_rem;
  logic         add_cy, add_ac, add_ov;
  logic         div_busy, div_last, div_zero;

  assign op     = alu_op_e'(op_i);
  assign accept = start_i && !div_busy;
  assign div_go = accept && (op == OP_DIV);

  alu_adder #(.W(W)) i_adder (
    .a_i   (acc_q),
    .b_i   (operand_i),
    .cin_i ((op == OP_ADDC) && flags_q.cy),
    .sum_o (add_sum),
    .cy_o  (add_cy),
    .ac_o  (add_ac),
    .ov_o  (add_ov)
  );

  alu_unary #(.W(W)) i_unary (
    .op_i  (op),
    .a_i   (acc_q),
    .b_i   (operand_i),
    .res_o (un_res)
  );

  alu_divider #(.W(W), .STEPS(DIV_STEPS)) i_divider (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_go),
    .dividend_i (acc_q),
    .divisor_i  (operand_i),
    .busy_o     (div_busy),
    .last_o     (div_last),
    .zero_o     (div_zero),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  always_comb begin
    acc_d = acc_q;
    b_d   = b_q;
    res   = flags_q;
    mask  = '0;
    if (div_last) begin
      acc_d  = div_quo;
      b_d    = div_rem;
      res.ov = div_zero;
      res.cy = 1'b0;
      mask   = upd_mask(OP_DIV);
    end else if (accept) begin
      unique case (op)
        OP_ADD, OP_ADDC: begin
          acc_d  = add_sum;
          res.cy = add_cy;
          res.ac = add_ac;
          res.ov = add_ov;
          mask   = upd_mask(op);
        end
        OP_DIV: mask = '0;
        default: begin
          acc_d = un_res;
          mask  = upd_mask(op);
        end
      endcase
    end
    res.p   = ^acc_d;
    flags_d = flags_t'((res & mask) | (flags_q & ~mask));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      b_q     <= '0;
      flags_q <= '0;
    end else begin
      acc_q   <= acc_d;
      b_q     <= b_d;
      flags_q <= flags_d;
    end
  end

  assign acc_o     = acc_q;
  assign b_o       = b_q;
  assign flag_p_o  = flags_q.p;
  assign flag_ov_o = flags_q.ov;
  assign flag_ac_o = flags_q.ac;
  assign flag_cy_o = flags_q.cy;
  assign busy_o    = div_busy;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] operand_i,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] b_o,
  input logic         flag_p_o,
  input logic         flag_ov_o,
  input logic         flag_ac_o,
  input logic         flag_cy_o,
  input logic         busy_o
);
  logic acc_ok;
  logic zero_q;

  assign acc_ok = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zero_q <= 1'b0;
    else if (acc_ok && op_i == 3'd7) zero_q <= (operand_i == '0);
  end

  assert_parity_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_p_o == ^acc_o);

  assert_add_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && op_i == 3'd0 |=> acc_o == W'($past(acc_o) + $past(operand_i)));

  assert_addc_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && op_i == 3'd1 |=>
      acc_o == W'($past(acc_o) + $past(operand_i) + {{(W-1){1'b0}}, $past(flag_cy_o)}));

  assert_and_keeps_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && op_i == 3'd2 |=> $stable({flag_ov_o, flag_ac_o, flag_cy_o}));

  assert_incdec_keeps_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && (op_i == 3'd3 || op_i == 3'd4) |=> $stable({flag_ov_o, flag_ac_o, flag_cy_o}));

  assert_clrcpl_keeps_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && (op_i == 3'd5 || op_i == 3'd6) |=> $stable({flag_ov_o, flag_ac_o, flag_cy_o}));

  assert_div_goes_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && op_i == 3'd7 |=> busy_o);

  assert_div_clears_cy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !flag_cy_o);

  assert_div_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && zero_q |-> flag_ov_o && acc_o == '1);

  assert_busy_holds_acc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(acc_o)));

  assert_b_only_on_div_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(b_o));
endmodule

bind acc_flag_alu acc_alu_checker #(.W(W)) i_acc_alu_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .acc_o     (acc_o),
  .b_o       (b_o),
  .flag_p_o  (flag_p_o),
  .flag_ov_o (flag_ov_o),
  .flag_ac_o (flag_ac_o),
  .flag_cy_o (flag_cy_o),
  .busy_o    (busy_o)
);

// File: tb/test_acc_flag_alu.sv
module test_acc_flag_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] op;
  logic [7:0] opnd;
  logic [7:0] acc, b;
  logic       fp, fov, fac, fcy, busy;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_acc, m_b;
  logic       m_p, m_ov, m_ac, m_cy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_flag_alu i_acc_flag_alu (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .op_i      (op),
    .operand_i (opnd),
    .acc_o     (acc),
    .b_o       (b),
    .flag_p_o  (fp),
    .flag_ov_o (fov),
    .flag_ac_o (fac),
    .flag_cy_o (fcy),
    .busy_o    (busy)
  );

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "acc", acc, m_acc);
    chk(req, "b", b, m_b);
    chk(req, "ov", {7'd0, fov}, {7'd0, m_ov});
    chk(req, "ac", {7'd0, fac}, {7'd0, m_ac});
    chk(req, "cy", {7'd0, fcy}, {7'd0, m_cy});
    chk("R7", "parity", {7'd0, fp}, {7'd0, m_p});
    chk(req, "busy", {7'd0, busy}, 8'd0);
  endtask

  task automatic model(logic [2:0] o, logic [7:0] d);
    logic [8:0] full;
    logic [4:0] low;
    logic [7:0] mid;
    logic       c;
    c = (o == 3'd1) ? m_cy : 1'b0;
    case (o)
      3'd0, 3'd1: begin
        full  = {1'b0, m_acc} + {1'b0, d} + {8'd0, c};
        low   = {1'b0, m_acc[3:0]} + {1'b0, d[3:0]} + {4'd0, c};
        mid   = {1'b0, m_acc[6:0]} + {1'b0, d[6:0]} + {7'd0, c};
        m_acc = full[7:0];
        m_cy  = full[8];
        m_ac  = low[4];
        m_ov  = mid[7] ^ full[8];
      end
      3'd2: m_acc = m_acc & d;
      3'd3: m_acc = m_acc + 8'd1;
      3'd4: m_acc = m_acc - 8'd1;
      3'd5: m_acc = 8'd0;
      3'd6: m_acc = ~m_acc;
      default: begin
        m_cy = 1'b0;
        if (d == 8'd0) begin
          m_b   = m_acc;
          m_acc = 8'hFF;
          m_ov  = 1'b1;
        end else begin
          m_b   = m_acc % d;
          m_acc = m_acc / d;
          m_ov  = 1'b0;
        end
      end
    endcase
    m_p = ^m_acc;
  endtask

  // issue at a falling edge, check at the following falling edges
  task automatic run_op(logic [2:0] o, logic [7:0] d);
    logic [7:0] held;
    start = 1'b1;
    op    = o;
    opnd  = d;
    @(negedge clk);
    start = 1'b0;
    if (o == 3'd7) begin
      held = acc;
      for (int k = 0; k < 4; k++) begin
        chk("R8", "busy during divide", {7'd0, busy}, 8'd1);
        chk("R10", "acc held while busy", acc, held);
        // stray request while busy must be dropped (R10)
        start = 1'b1;
        op    = 3'($urandom_range(0, 7));
        opnd  = 8'($urandom);
        @(negedge clk);
        start = 1'b0;
      end
    end
    model(o, d);
    check_all((o == 3'd7 && d == 8'd0) ? "R9" : req_of(o));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    start = 1'b0;
    op    = 3'd0;
    opnd  = 8'd0;
    m_acc = 8'd0; m_b = 8'd0;
    m_p = 1'b0; m_ov = 1'b0; m_ac = 1'b0; m_cy = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // directed: signed overflow and half carry (R2)
    run_op(3'd0, 8'h7F);
    run_op(3'd0, 8'h01);
    // carry out of bit 7 then chained carry (R2, R3)
    run_op(3'd0, 8'hFF);
    run_op(3'd1, 8'h00);
    run_op(3'd1, 8'h80);
    // flags must persist across logic ops (R4, R5, R6)
    run_op(3'd0, 8'h80);
    run_op(3'd2, 8'h5A);
    run_op(3'd5, 8'h00);
    run_op(3'd4, 8'h00);
    run_op(3'd3, 8'h00);
    run_op(3'd6, 8'h00);
    run_op(3'd3, 8'h00);
    run_op(3'd4, 8'h00);
    // divides (R8, R9)
    run_op(3'd5, 8'h00);
    run_op(3'd0, 8'd200);
    run_op(3'd7, 8'd7);
    run_op(3'd7, 8'd1);
    run_op(3'd7, 8'd0);
    run_op(3'd7, 8'hFF);
    run_op(3'd7, 8'd0);

    // random mix (R2..R10)
    for (int n = 0; n < 500; n++) begin
      run_op(3'($urandom_range(0, 7)), 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule